// File: doc/BRIEF.md
# Multiphase Drift Time Sampler

This block gives each of a set of straw-tube discriminator channels a time stamp finer than one bunch-crossing period. A 40 MHz core clock period is cut into eight equal slots by eight phase strobes, each rising once per period and spaced about 3 ns apart. Every strobe captures the state of all channels into a front-end holding register of its own. On the next core clock edge the eight captured snapshots are moved together into the core-clock register stage, packed into one wide sample word and presented with a write address for a latency memory downstream.

Each channel input is a three-level comparator signal, coded on two wires: `00` quiescent, `01` track, `11` track plus transition radiation. The block turns this into a low-threshold bit per phase and one high-threshold flag per period. The fourth code, `10`, cannot arise from a healthy receiver. It produces no hit and is tallied in a saturating error counter. The write address moves on every core clock and never stalls, so the memory behind the block always holds the most recent `DEPTH` periods.

Top module: `drift_sampler`

## Requirements
- R1: While reset is asserted, and until the first core clock edge after its release, `wr_valid_o` is 0 and `wr_addr_o`, `wr_word_o` and `ill_cnt_o` are all zero.
- R2: Channel code `01` sets only the low-threshold result and code `11` sets both low and high. Code `00` sets neither. A high flag therefore never appears in a channel slice whose eight low bits are all zero.
- R3: Channel c occupies bits `[c*9+8 : c*9]` of `wr_word_o`. Bit `c*9+(7-p)` holds the low-threshold result captured by phase strobe p, so the eight low bits read in time order from their most significant end. A hit that only reaches phases 6 and 7 gives `00000011`.
- R4: Bit `c*9+8` is the OR, over all eight phases of the period, of the high-threshold result of channel c.
- R5: The word for the period that ends at core clock edge k appears on `wr_word_o` right after edge k and stays there for exactly one period.
- R6: Code `10` sets neither bit of its phase. Each channel that shows `10` on at least one phase of a period adds exactly one to `ill_cnt_o` after that period's closing edge.
- R7: `ill_cnt_o` saturates at `2^ILL_W - 1` and never decreases while out of reset.
- R8: `wr_valid_o` rises at the first core clock edge after reset release and stays at 1 from then on. The first valid word carries address 0.
- R9: `wr_addr_o` grows by one on every core clock while valid and wraps from `DEPTH-1` to 0.
- R10: Channels are independent. The slice of one channel depends only on that channel's input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 40 MHz core clock, one period per bunch crossing |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_stb_i | input | NPH | Phase strobes, bit p rises once per period at slot p |
| chan_lvl_i | input | 2*NCH | Two-bit three-level code per channel, channel c at bits `[2c+1:2c]` |
| wr_valid_o | output | 1 | Sample word valid for writing |
| wr_addr_o | output | $clog2(DEPTH) | Write address into the latency memory |
| wr_word_o | output | NCH*(NPH+1) | Packed per-channel phase pattern and high flag |
| ill_cnt_o | output | ILL_W | Saturating count of channels that showed the illegal code |

## Verification
The bench builds the block with 16 channels and 8 phases, as in the default, but shrinks the address space to `DEPTH = 16` and the error counter to `ILL_W = 4`. With these values the address wrap falls within about twenty periods, and a few periods with several bad channels drive the counter into saturation. The phase strobes are placed 3 time units apart inside a 24-unit period, so single-phase hits, late rises and a high level on only one phase can be placed exactly and checked bit by bit.

// File: rtl/ds_pkg.sv
package ds_pkg;

    typedef enum logic [1:0] {
        LVL_QUIET = 2'b00,
        LVL_TRACK = 2'b01,
        LVL_BAD   = 2'b10,
        LVL_TRTRK = 2'b11
    } level_e;

    typedef struct packed {
        logic bad;
        logic high;
        logic low;
    } hit_t;

    function automatic hit_t decode_level(input logic [1:0] code);
        hit_t h;
        h = '0;
        case (level_e'(code))
            LVL_TRACK: h.low  = 1'b1;
            LVL_TRTRK: begin
                h.low  = 1'b1;
                h.high = 1'b1;
            end
            LVL_BAD:   h.bad  = 1'b1;
            default:   h      = '0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/ds_level_decode.sv
module ds_level_decode #(
    parameter int NCH = 16
) (
    input  logic [2*NCH-1:0] code_i,
    output logic [NCH-1:0]   low_o,
    output logic [NCH-1:0]   high_o,
    output logic [NCH-1:0]   bad_o
);
    import ds_pkg::*;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        hit_t hit;
        assign hit       = decode_level(code_i[2*c +: 2]);
        assign low_o[c]  = hit.low;
        assign high_o[c] = hit.high;
        assign bad_o[c]  = hit.bad;
    end

endmodule

// File: rtl/ds_phase_latch.sv
module ds_phase_latch #(
    parameter int NCH = 16
) (
    input  logic           strobe_i,
    input  logic           rst_ni,
    input  logic [NCH-1:0] low_i,
    input  logic [NCH-1:0] high_i,
    input  logic [NCH-1:0] bad_i,
    output logic [NCH-1:0] low_o,
    output logic [NCH-1:0] high_o,
    output logic [NCH-1:0] bad_o
);
    logic [NCH-1:0] low_q, high_q, bad_q;

    // Front-end capture: one register bank clocked by its own phase strobe.
    always_ff @(posedge strobe_i or negedge rst_ni) begin
        if (!rst_ni) begin
            low_q  <= '0;
            high_q <= '0;
            bad_q  <= '0;
        end else begin
            low_q  <= low_i;
            high_q <= high_i;
            bad_q  <= bad_i;
        end
    end

    assign low_o  = low_q;
    assign high_o = high_q;
    assign bad_o  = bad_q;

endmodule

// File: rtl/ds_word_pack.sv
module ds_word_pack #(
    parameter int NCH  = 16,
    parameter int NPH  = 8,
    localparam int SW   = NPH + 1,
    localparam int WW   = NCH * SW,
    localparam int CNTW = $clog2(NCH + 1)
) (
    input  logic [NPH*NCH-1:0] low_ph_i,   // index p*NCH + c
    input  logic [NPH*NCH-1:0] high_ph_i,
    input  logic [NPH*NCH-1:0] bad_ph_i,
    output logic [WW-1:0]      word_o,
    output logic [CNTW-1:0]    bad_cnt_o
);
    always_comb begin
        word_o    = '0;
        bad_cnt_o = '0;
        for (int c = 0; c < NCH; c++) begin
            logic any_bad;
            logic any_high;
            any_bad  = 1'b0;
            any_high = 1'b0;
            for (int p = 0; p < NPH; p++) begin
                // earliest phase lands in the most significant low bit
                word_o[c*SW + (NPH-1-p)] = low_ph_i[p*NCH + c];
                any_high = any_high | high_ph_i[p*NCH + c];
                any_bad  = any_bad  | bad_ph_i[p*NCH + c];
            end
            word_o[c*SW + NPH] = any_high;
            if (any_bad) begin
                bad_cnt_o = bad_cnt_o + CNTW'(1);
            end
        end
    end

endmodule

// File: rtl/drift_sampler.sv
module drift_sampler #(
    parameter int NCH   = 16,
    parameter int NPH   = 8,
    parameter int DEPTH = 128,
    parameter int ILL_W = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int SW   = NPH + 1,
    localparam int WW   = NCH * SW,
    localparam int CNTW = $clog2(NCH + 1),
    localparam int SUMW = ((ILL_W > CNTW) ? ILL_W : CNTW) + 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NPH-1:0]     phase_stb_i,
    input  logic [2*NCH-1:0]   chan_lvl_i,
    output logic               wr_valid_o,
    output logic [AW-1:0]      wr_addr_o,
    output logic [WW-1:0]      wr_word_o,
    output logic [ILL_W-1:0]   ill_cnt_o
);

    typedef struct packed {
        logic             valid;
        logic [AW-1:0]    addr;
        logic [WW-1:0]    word;
        logic [ILL_W-1:0] ill;
    } state_t;

    logic [NCH-1:0]     low_now, high_now, bad_now;
    logic [NPH*NCH-1:0] low_ph, high_ph, bad_ph;
    logic [WW-1:0]      packed_word;
    logic [CNTW-1:0]    bad_cnt;
    logic [SUMW-1:0]    ill_sum;
    state_t             st_d, st_q;

    ds_level_decode #(.NCH(NCH)) dec_i (
        .code_i (chan_lvl_i),
        .low_o  (low_now),
        .high_o (high_now),
        .bad_o  (bad_now)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        ds_phase_latch #(.NCH(NCH)) lat_i (
            .strobe_i (phase_stb_i[p]),
            .rst_ni   (rst_ni),
            .low_i    (low_now),
            .high_i   (high_now),
            .bad_i    (bad_now),
            .low_o    (low_ph[p*NCH +: NCH]),
            .high_o   (high_ph[p*NCH +: NCH]),
            .bad_o    (bad_ph[p*NCH +: NCH])
        );
    end

    ds_word_pack #(.NCH(NCH), .NPH(NPH)) pack_i (
        .low_ph_i  (low_ph),
        .high_ph_i (high_ph),
        .bad_ph_i  (bad_ph),
        .word_o    (packed_word),
        .bad_cnt_o (bad_cnt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b1;
        st_d.word  = packed_word;
        if (!st_q.valid || st_q.addr == AW'(DEPTH - 1)) begin
            st_d.addr = '0;
        end else begin
            st_d.addr = st_q.addr + AW'(1);
        end
        ill_sum = SUMW'(st_q.ill) + SUMW'(bad_cnt);
        if (ill_sum > SUMW'({ILL_W{1'b1}})) begin
            st_d.ill = '1;
        end else begin
            st_d.ill = ill_sum[ILL_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_valid_o = st_q.valid;
    assign wr_addr_o  = st_q.addr;
    assign wr_word_o  = st_q.word;
    assign ill_cnt_o  = st_q.ill;

endmodule

// File: rtl/ds_checker.sv
module ds_checker #(
    parameter int NCH   = 16,
    parameter int NPH   = 8,
    parameter int DEPTH = 128,
    parameter int ILL_W = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int SW   = NPH + 1,
    localparam int WW   = NCH * SW
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_valid_o,
    input logic [AW-1:0]    wr_addr_o,
    input logic [WW-1:0]    wr_word_o,
    input logic [ILL_W-1:0] ill_cnt_o
);
    logic [NCH-1:0] orphan_high;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            orphan_high[c] = wr_word_o[c*SW + NPH] & ~(|wr_word_o[c*SW +: NPH]);
        end
    end

    AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_valid_o |-> (wr_addr_o == '0 && wr_word_o == '0 && ill_cnt_o == '0)); // R1

    AST_HIGH_NEEDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        orphan_high == '0); // R2

    AST_ILL_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_o |=> (ill_cnt_o >= $past(ill_cnt_o))); // R7

    AST_VALID_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_o |=> wr_valid_o); // R8

    AST_FIRST_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wr_valid_o) |-> (wr_addr_o == '0)); // R8

    AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_o |=> (wr_addr_o == (($past(wr_addr_o) == AW'(DEPTH - 1)) ?
                                      AW'(0) : $past(wr_addr_o) + AW'(1)))); // R9

endmodule

bind drift_sampler ds_checker #(
    .NCH   (NCH),
    .NPH   (NPH),
    .DEPTH (DEPTH),
    .ILL_W (ILL_W)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_word_o  (wr_word_o),
    .ill_cnt_o  (ill_cnt_o)
);

// File: tb/drift_sampler_tb_top.sv
module drift_sampler_tb_top;

    localparam int CLK_PERIOD = 24;
    localparam int NCH   = 16;
    localparam int NPH   = 8;
    localparam int DEPTH = 16;
    localparam int ILL_W = 4;
    localparam int BIN   = CLK_PERIOD / NPH;
    localparam int AW    = $clog2(DEPTH);
    localparam int SW    = NPH + 1;
    localparam int WW    = NCH * SW;
    localparam int ILL_MAX = (1 << ILL_W) - 1;

    logic               clk;
    logic               rst_n;
    logic [NPH-1:0]     stb;
    logic [2*NCH-1:0]   chan_lvl;
    logic               wr_valid;
    logic [AW-1:0]      wr_addr;
    logic [WW-1:0]      wr_word;
    logic [ILL_W-1:0]   ill_cnt;

    drift_sampler #(.NCH(NCH), .NPH(NPH), .DEPTH(DEPTH), .ILL_W(ILL_W)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .phase_stb_i (stb),
        .chan_lvl_i  (chan_lvl),
        .wr_valid_o  (wr_valid),
        .wr_addr_o   (wr_addr),
        .wr_word_o   (wr_word),
        .ill_cnt_o   (ill_cnt)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [1:0]     stim [NPH][NCH];
    int             n_edges   = 0;
    logic [WW-1:0]  prev_word = '0;
    int             model_ill = 0;
    string          prev_tag  = "R8";

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    // phase strobe p rises at 1 + p*BIN after each core edge
    initial stb = '0;
    always @(posedge clk) begin
        for (int p = 0; p < NPH; p++) begin
            #((p == 0) ? 1 : BIN - 1) stb[p] = 1'b1;
            #1 stb[p] = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [WW-1:0] got, input logic [WW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [WW-1:0] calc_word();
        logic [WW-1:0] w;
        w = '0;
        for (int c = 0; c < NCH; c++) begin
            for (int p = 0; p < NPH; p++) begin
                if (stim[p][c] == 2'b01 || stim[p][c] == 2'b11) w[c*SW + (NPH-1-p)] = 1'b1;
                if (stim[p][c] == 2'b11) w[c*SW + NPH] = 1'b1;
            end
        end
        return w;
    endfunction

    function automatic int calc_bad();
        int n;
        n = 0;
        for (int c = 0; c < NCH; c++) begin
            bit any;
            any = 1'b0;
            for (int p = 0; p < NPH; p++) if (stim[p][c] == 2'b10) any = 1'b1;
            if (any) n++;
        end
        return n;
    endfunction

    task automatic clear_stim();
        for (int p = 0; p < NPH; p++)
            for (int c = 0; c < NCH; c++) stim[p][c] = 2'b00;
    endtask

    // Starts on a core edge, drives one period, checks outputs of the previous period.
    task automatic step(input string tag);
        n_edges++;
        for (int p = 0; p < NPH; p++) begin
            if (p == NPH/2) begin
                chk("R8 valid", WW'(wr_valid), WW'(1'b1));
                chk("R9 address", WW'(wr_addr), WW'((n_edges - 1) % DEPTH));
                chk({prev_tag, " R5 word"}, wr_word, prev_word);
                chk("R6/R7 illegal count", WW'(ill_cnt), WW'(model_ill));
            end
            for (int c = 0; c < NCH; c++) chan_lvl[2*c +: 2] = stim[p][c];
            #(BIN);
        end
        prev_word = calc_word();
        model_ill = model_ill + calc_bad();
        if (model_ill > ILL_MAX) model_ill = ILL_MAX;
        prev_tag  = tag;
    endtask

    task automatic test_reset();
        #6;
        chk("R1 valid", WW'(wr_valid), '0);
        chk("R1 address", WW'(wr_addr), '0);
        chk("R1 word", wr_word, '0);
        chk("R1 count", WW'(ill_cnt), '0);
    endtask

    task automatic test_decode();
        clear_stim();
        for (int p = 0; p < NPH; p++) begin
            stim[p][0] = 2'b01;
            stim[p][1] = 2'b11;
            stim[p][2] = 2'b00;
            stim[p][9] = (p % 2 == 0) ? 2'b01 : 2'b11;
        end
        step("R2 R10");
        clear_stim();
        step("R2");
    endtask

    task automatic test_late_rise();
        clear_stim();
        stim[6][3] = 2'b01;
        stim[7][3] = 2'b01;
        step("R3 late rise 00000011");
        clear_stim();
        for (int p = 0; p < NPH - 1; p++) stim[p][3] = 2'b01;
        step("R3 pattern 11111110");
        clear_stim();
        for (int c = 0; c < NCH; c++) stim[c % NPH][c] = 2'b01;
        step("R3 R10 diagonal");
        clear_stim();
        step("R3");
    endtask

    task automatic test_high_or();
        clear_stim();
        for (int p = 0; p < NPH; p++) stim[p][5] = 2'b01;
        stim[3][5]  = 2'b11;
        stim[7][6]  = 2'b11;
        stim[0][15] = 2'b11;
        step("R4 single-phase high");
        clear_stim();
        step("R4");
    endtask

    task automatic test_illegal();
        clear_stim();
        stim[2][7] = 2'b10;
        stim[4][7] = 2'b01;
        stim[1][8] = 2'b10;
        stim[5][8] = 2'b10;
        step("R6 illegal code");
        clear_stim();
        step("R6");
    endtask

    task automatic test_saturate();
        for (int k = 0; k < 3; k++) begin
            clear_stim();
            for (int c = 10; c < 16; c++) stim[0][c] = 2'b10;
            step("R7 saturation");
        end
        clear_stim();
        step("R7");
        step("R7");
        chk("R7 saturated value", WW'(ill_cnt), WW'(ILL_MAX));
    endtask

    task automatic test_wrap();
        clear_stim();
        for (int k = 0; k < DEPTH + 4; k++) begin
            stim[k % NPH][k % NCH] = 2'b01;
            step("R9 wrap");
            clear_stim();
        end
        step("R9");
    endtask

    initial begin
        rst_n    = 1'b0;
        chan_lvl = '0;
        clear_stim();
        @(posedge clk);
        test_reset();
        rst_n = 1'b1;
        @(posedge clk);
        test_decode();
        test_late_rise();
        test_high_or();
        test_illegal();
        test_saturate();
        test_wrap();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule